// File: doc/BRIEF.md
# Flash Command Sequencer and Status Register

This block is the command front end of an emulated NOR flash device. Bus writes arrive as single-cycle strobes that carry a command byte in the low eight data bits, or an address/data pair. The block decodes one-cycle commands and two-cycle setup/confirm sequences. It selects the source the read path returns (array, identifier/configuration space, or status) and holds the status register. It also issues one-cycle operation requests to the internal algorithm engine, and it drives the ready/busy output and the suspend hold for that engine.

Any failure in a sequence leaves sticky error bits in the status register. These bits stay set until software sends the clear command. Status is presented through a capture register that loads only when the read enables go active. Reads from the host therefore see a value that stays fixed for the whole access. The engine reports its activity on one busy input. Supply health and the protection state of the addressed target also arrive as single input bits.

Top module: `flash_cmd_front`

## Requirements
- R1: While `rst_n` is low, the block aborts any pending sequence and any suspend. It returns `rd_sel` to 0 (array) and sets `sr_q` to 80h. With the engine idle, `ry_by` is 1 after reset.
- R2: Command FFh sets `rd_sel` to 0 (array), 90h sets it to 1 (identifier) and 70h sets it to 2 (status). The command byte is `wr_data[7:0]`.
- R3: While `eng_busy` is 1 and the block is not suspended, FFh is ignored. While `eng_busy` is 1, setup bytes (20h, 30h, 40h, 10h, 60h, C0h) are ignored and start no sequence.
- R4: Setup 20h followed by D0h requests block erase (`op_kind` 1). Setup 30h followed by D0h requests chip erase (`op_kind` 2). `op_valid` is a one-cycle pulse, and `op_addr` carries the address of the confirm write. Every accepted setup and every second cycle sets `rd_sel` to 2.
- R5: Setup 40h or 10h followed by an address/data write requests a word write (`op_kind` 3). Setup C0h followed by such a write requests an OTP program (`op_kind` 4). `op_addr` and `op_data` carry that second write.
- R6: After setup 60h, confirm 01h requests set-block-lock (`op_kind` 5), D0h requests clear-all-locks (`op_kind` 6) and F1h requests set-permanent-lock (`op_kind` 7). Any other confirm sets SR.5 and SR.4. For the supply and protection errors of R8 and R9, lock sequences count as erase class for D0h and as write class for 01h and F1h.
- R7: A block or chip erase whose confirm byte is not D0h sets SR.5 and SR.4 and requests nothing.
- R8: If `supply_ok` is 0 on the second cycle, the block sets SR.3 together with SR.5 (erase class) or SR.4 (write class), and requests nothing.
- R9: If `tgt_protected` is 1 on the second cycle and the supply is good, the block sets SR.1 together with SR.5 or SR.4 by class, and requests nothing.
- R10: SR.5, SR.4, SR.3 and SR.1 stay set until command 50h clears them. While suspended, 50h has no effect.
- R11: B0h issued while the engine runs sets `eng_suspend`. It also sets SR.6 when the running operation is an erase, or SR.2 when it is a write. D0h issued while suspended clears `eng_suspend`. While suspended, SR.7 is 1. Bits SR.0 and the unused flags read 0.
- R12: `ry_by` is 0 exactly while `eng_busy` is 1 and the block is not suspended. SR.7 mirrors `ry_by`.
- R13: `sr_q` loads the live status on the cycle after both `oe_n` and `ce_n` become low. It does not change again until one of them returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, aborts everything |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command byte in bits 7:0 |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| supply_ok | input | 1 | Write supply is in range |
| tgt_protected | input | 1 | Target of the current write is protected |
| eng_busy | input | 1 | Engine holds an operation |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| sr_q | output | 8 | Captured status register |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | Requested operation code |
| op_addr | output | AW | Operation address |
| op_data | output | DW | Operation data |
| eng_suspend | output | 1 | Engine hold (suspend) |
| ry_by | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest state to reach from the ports is a suspended erase that carries sticky errors from earlier sequences. In that state the clear command must be refused, and it must take effect again once the operation resumes. The stimulus first produces an invalid confirm and a valid erase with the engine idle. It then raises the busy input, suspends, sends 50h and reads status twice around the resume. A random phase mixes every setup byte with valid, invalid and arbitrary confirms under random supply and protection inputs. A bench function predicts the error bits and the request for each case.

// File: rtl/flash_cmd_front.sv
module flash_cmd_front #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          oe_n,
  input  logic          ce_n,
  input  logic          supply_ok,
  input  logic          tgt_protected,
  input  logic          eng_busy,
  output logic [1:0]    rd_sel,
  output logic [7:0]    sr_q,
  output logic          op_valid,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          eng_suspend,
  output logic          ry_by
);
  localparam logic [1:0] SEL_ARRAY = 2'd0, SEL_IDENT = 2'd1, SEL_STAT = 2'd2;
  localparam logic [7:0] C_ARRAY = 8'hFF, C_IDENT = 8'h90, C_STAT = 8'h70, C_CLR = 8'h50,
                         C_SUSP = 8'hB0, C_CONF = 8'hD0, C_BLK = 8'h20, C_CHIP = 8'h30,
                         C_WR1 = 8'h40, C_WR2 = 8'h10, C_LOCK = 8'h60, C_OTP = 8'hC0,
                         C_LSET = 8'h01, C_LPERM = 8'hF1;

  typedef enum logic [2:0] {PN_NONE, PN_BLK, PN_CHIP, PN_WORD, PN_OTP, PN_LOCK} pend_t;

  pend_t      pend;
  logic [7:0] cmd;
  logic       e5, e4, e3, e1;
  logic       susp, susp_erase, cur_erase, rd_act_d;
  logic [3:0] err_new;
  logic [2:0] nk;

  wire run    = eng_busy & ~susp;
  wire rd_act = ~oe_n & ~ce_n;
  wire [7:0] sr_live = {~run, susp & susp_erase, e5, e4, e3, susp & ~susp_erase, e1, 1'b0};

  assign cmd         = wr_data[7:0];
  assign eng_suspend = susp;
  assign ry_by       = ~run;

  always_comb begin
    err_new = 4'b0000;
    nk      = 3'd0;
    case (pend)
      PN_BLK, PN_CHIP: begin
        if (cmd != C_CONF)   err_new = 4'b1100;
        else if (!supply_ok) err_new = 4'b1010;
        else if (tgt_protected) err_new = 4'b1001;
        else nk = (pend == PN_BLK) ? 3'd1 : 3'd2;
      end
      PN_WORD, PN_OTP: begin
        if (!supply_ok)         err_new = 4'b0110;
        else if (tgt_protected) err_new = 4'b0101;
        else nk = (pend == PN_WORD) ? 3'd3 : 3'd4;
      end
      PN_LOCK: begin
        if (cmd != C_LSET && cmd != C_CONF && cmd != C_LPERM) err_new = 4'b1100;
        else if (!supply_ok)    err_new = (cmd == C_CONF) ? 4'b1010 : 4'b0110;
        else if (tgt_protected) err_new = (cmd == C_CONF) ? 4'b1001 : 4'b0101;
        else nk = (cmd == C_CONF) ? 3'd6 : (cmd == C_LSET) ? 3'd5 : 3'd7;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= PN_NONE;
      rd_sel     <= SEL_ARRAY;
      sr_q       <= 8'h80;
      {e5, e4, e3, e1} <= 4'b0000;
      susp       <= 1'b0;
      susp_erase <= 1'b0;
      cur_erase  <= 1'b0;
      rd_act_d   <= 1'b1;
      op_valid   <= 1'b0;
      op_kind    <= 3'd0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      op_valid <= 1'b0;
      rd_act_d <= rd_act;
      if (rd_act && !rd_act_d) sr_q <= sr_live;
      if (!eng_busy) susp <= 1'b0;
      if (wr_en) begin
        if (pend != PN_NONE) begin
          pend   <= PN_NONE;
          rd_sel <= SEL_STAT;
          {e5, e4, e3, e1} <= {e5, e4, e3, e1} | err_new;
          if (nk != 3'd0) begin
            op_valid  <= 1'b1;
            op_kind   <= nk;
            op_addr   <= wr_addr;
            op_data   <= wr_data;
            cur_erase <= (nk == 3'd1) || (nk == 3'd2);
          end
        end else begin
          case (cmd)
            C_ARRAY: if (!run) rd_sel <= SEL_ARRAY;
            C_IDENT: rd_sel <= SEL_IDENT;
            C_STAT:  rd_sel <= SEL_STAT;
            C_CLR:   if (!susp) {e5, e4, e3, e1} <= 4'b0000;
            C_SUSP:  if (run) begin
              susp       <= 1'b1;
              susp_erase <= cur_erase;
              rd_sel     <= SEL_STAT;
            end
            C_CONF:  if (susp) begin
              susp   <= 1'b0;
              rd_sel <= SEL_STAT;
            end
            C_BLK:   if (!eng_busy) begin pend <= PN_BLK;  rd_sel <= SEL_STAT; end
            C_CHIP:  if (!eng_busy) begin pend <= PN_CHIP; rd_sel <= SEL_STAT; end
            C_WR1, C_WR2: if (!eng_busy) begin pend <= PN_WORD; rd_sel <= SEL_STAT; end
            C_LOCK:  if (!eng_busy) begin pend <= PN_LOCK; rd_sel <= SEL_STAT; end
            C_OTP:   if (!eng_busy) begin pend <= PN_OTP;  rd_sel <= SEL_STAT; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module flash_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_n,
  input logic       ce_n,
  input logic       supply_ok,
  input logic       tgt_protected,
  input logic       eng_busy,
  input logic [1:0] rd_sel,
  input logic [7:0] sr_q,
  input logic       op_valid,
  input logic       eng_suspend,
  input logic       ry_by
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> (sr_q == 8'h80 && rd_sel == 2'd0 && !op_valid && !eng_suspend));

  assert_op_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  assert_op_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(supply_ok));

  assert_op_unprotected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !$past(tgt_protected));

  assert_suspend_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspend |-> ry_by);

  assert_idle_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> ry_by);

  assert_status_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !ce_n && $past(!oe_n && !ce_n)) |-> $stable(sr_q));
endmodule

bind flash_cmd_front flash_cmd_front_chk chk_i (.*);

// File: tb/flash_cmd_front_tb_top.sv
module flash_cmd_front_tb_top;
  localparam int AW = 22, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic oe_n = 1'b1, ce_n = 1'b0, supply_ok = 1'b1, tgt_protected = 1'b0, eng_busy = 1'b0;
  logic [1:0] rd_sel;
  logic [7:0] sr_q;
  logic op_valid, eng_suspend, ry_by;
  logic [2:0] op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int checks = 0, errors = 0;
  logic [7:0] stick = 8'h00;

  always #4 clk = ~clk;

  flash_cmd_front #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oe_n(oe_n), .ce_n(ce_n), .supply_ok(supply_ok), .tgt_protected(tgt_protected),
    .eng_busy(eng_busy), .rd_sel(rd_sel), .sr_q(sr_q), .op_valid(op_valid),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .eng_suspend(eng_suspend), .ry_by(ry_by));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk); v = sr_q; oe_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_err(input logic [7:0] s, input logic [7:0] c,
                                         input logic sup, input logic prot);
    logic [7:0] cls;
    if (s == 8'h20 || s == 8'h30) begin
      if (c != 8'hD0) return 8'h30;
      if (!sup) return 8'h28;
      if (prot) return 8'h22;
      return 8'h00;
    end
    if (s == 8'h60) begin
      if (c != 8'h01 && c != 8'hD0 && c != 8'hF1) return 8'h30;
      cls = (c == 8'hD0) ? 8'h20 : 8'h10;
      if (!sup) return 8'h08 | cls;
      if (prot) return 8'h02 | cls;
      return 8'h00;
    end
    if (!sup) return 8'h18;
    if (prot) return 8'h12;
    return 8'h00;
  endfunction

  function automatic logic [2:0] exp_kind(input logic [7:0] s, input logic [7:0] c,
                                          input logic sup, input logic prot);
    if (exp_err(s, c, sup, prot) != 8'h00) return 3'd0;
    case (s)
      8'h20: return 3'd1;
      8'h30: return 3'd2;
      8'h40, 8'h10: return 3'd3;
      8'hC0: return 3'd4;
      default: return (c == 8'h01) ? 3'd5 : (c == 8'hD0) ? 3'd6 : 3'd7;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_sel", rd_sel, 2'd0);
    check("R1 ry_by", ry_by, 1'b1);
    rd_status(v); check("R1 status", v, 8'h80);

    wr(0, 16'h0090); check("R2 ident", rd_sel, 2'd1);
    wr(0, 16'h0070); check("R2 status", rd_sel, 2'd2);
    wr(0, 16'h00FF); check("R2 array", rd_sel, 2'd0);

    supply_ok = 1'b0;
    wr(0, 16'h0020); wr(22'h100, 16'h00D0);
    check("R8 no op", op_valid, 1'b0);
    supply_ok = 1'b1;
    rd_status(v); check("R8 erase low supply", v, 8'hA8);

    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    check("R13 captured", sr_q, 8'hA8);
    wr(0, 16'h0050);
    check("R13 hold while low", sr_q, 8'hA8);
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    rd_status(v); check("R10 clear", v, 8'h80);

    tgt_protected = 1'b1;
    wr(0, 16'h0040); wr(22'h55, 16'h1234);
    tgt_protected = 1'b0;
    check("R9 no op", op_valid, 1'b0);
    rd_status(v); check("R9 write protected", v, 8'h92);
    wr(0, 16'h0050);

    wr(0, 16'h0020); wr(22'h200, 16'h0055);
    check("R7 no op", op_valid, 1'b0);
    wr(0, 16'h0020); wr(22'h3ABCD, 16'h00D0);
    check("R4 op_valid", op_valid, 1'b1);
    check("R4 kind", op_kind, 3'd1);
    check("R4 addr", op_addr, 22'h3ABCD);
    check("R4 rd_sel", rd_sel, 2'd2);
    @(negedge clk);
    check("R4 pulse", op_valid, 1'b0);
    eng_busy = 1'b1;
    @(negedge clk);
    check("R12 busy", ry_by, 1'b0);
    wr(0, 16'h00FF); check("R3 array refused", rd_sel, 2'd2);
    wr(0, 16'h0020); wr(0, 16'h00D0);
    check("R3 setup ignored", op_valid, 1'b0);
    wr(0, 16'h00B0);
    check("R11 suspend", eng_suspend, 1'b1);
    check("R11 ready", ry_by, 1'b1);
    rd_status(v); check("R11 erase suspended status", v, 8'hF0);
    wr(0, 16'h0050);
    rd_status(v); check("R10 clear ignored while suspended", v, 8'hF0);
    wr(0, 16'h00FF); check("R3 array while suspended", rd_sel, 2'd0);
    wr(0, 16'h00D0);
    check("R11 resume", eng_suspend, 1'b0);
    check("R12 busy after resume", ry_by, 1'b0);
    wr(0, 16'h0050);
    rd_status(v); check("R10 clear after resume", v, 8'h00);
    eng_busy = 1'b0;
    @(negedge clk);

    wr(0, 16'h0010); wr(22'h77, 16'hBEEF);
    check("R5 kind", op_kind, 3'd3);
    check("R5 data", op_data, 16'hBEEF);
    eng_busy = 1'b1;
    wr(0, 16'h00B0);
    rd_status(v); check("R11 write suspended status", v, 8'h84);
    eng_busy = 1'b0;
    @(negedge clk);
    check("R11 suspend drops when idle", eng_suspend, 1'b0);

    wr(0, 16'h00C0); wr(22'h80, 16'hFFFD);
    check("R5 otp kind", op_kind, 3'd4);
    wr(0, 16'h0060); wr(0, 16'h00F1);
    check("R6 perm kind", op_kind, 3'd7);
    wr(0, 16'h0060); wr(0, 16'h0077);
    check("R6 bad confirm no op", op_valid, 1'b0);
    rd_status(v); check("R6 bad confirm", v, 8'hB0);

    wr(0, 16'h0090);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_sel after reset", rd_sel, 2'd0);
    rd_status(v); check("R1 status after reset", v, 8'h80);

    stick = 8'h00;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] s, c;
      logic sup, prot;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [2:0] k;
      case ($urandom % 6)
        0: s = 8'h20; 1: s = 8'h30; 2: s = 8'h40;
        3: s = 8'h10; 4: s = 8'h60; default: s = 8'hC0;
      endcase
      case ($urandom % 5)
        0, 4: c = 8'hD0; 1: c = 8'h01; 2: c = 8'hF1; default: c = 8'($urandom);
      endcase
      sup  = ($urandom % 4) != 0;
      prot = ($urandom % 4) == 0;
      a = AW'($urandom);
      d = {8'($urandom), c};
      k = exp_kind(s, c, sup, prot);
      stick = stick | exp_err(s, c, sup, prot);
      wr(0, {8'h00, s});
      supply_ok = sup; tgt_protected = prot;
      wr(a, d);
      supply_ok = 1'b1; tgt_protected = 1'b0;
      check("R4 R5 R6 random request", op_valid, k != 3'd0);
      if (k != 3'd0) begin
        check("R4 R5 R6 random kind", op_kind, k);
        check("R4 R5 random addr", op_addr, a);
        check("R5 random data", op_data, d);
      end
      rd_status(v);
      check("R7 R8 R9 R10 random status", v, 8'h80 | stick);
      if (($urandom % 3) == 0) begin
        wr(0, 16'h0050);
        stick = 8'h00;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule